// File: doc/BRIEF.md
# Grouped Sixteen-Bit ALU with Registered Result

This block is the arithmetic and logic unit of a small four-register processor. Each cycle it takes two register operands, the current program counter and an 8-bit immediate field. A 2-bit group select and a 3-bit op select choose one function. The block returns a 16-bit result and a carry bit, both registered, so the result appears one clock after the inputs are presented.

There are four groups:

- **Register-pair group.** Add, subtract, program-counter-relative add, and, or and xor, plus two copy slots.
- **Single-register group.** Increment, decrement, negate and complement.
- **Immediate shift and bit group.** The high nibble of the immediate picks the operation and the low nibble gives the shift amount or bit index.
- **Sign-extended immediate add.** Adds the immediate to register a.

The carry output lets software build wider additions from 16-bit pieces. All adding functions share one adder.

Top module: `ccalu_core`

## Requirements
- R1: A synchronous active-high reset clears `result` and `carry` to 0. Outside reset, both outputs take the value computed from the inputs of the previous rising edge, giving a latency of one cycle.
- R2: With `grp_sel`=0, op 2 gives a+b and op 4 gives pc+b. Both wrap modulo 2^16, and `carry` is the bit-16 carry-out of the sum.
- R3: With `grp_sel`=0 and op 3, the result is a-b modulo 2^16. `carry` is 1 exactly when a >= b as unsigned numbers.
- R4: With `grp_sel`=0, the remaining codes behave as follows, each with `carry`=0:
  - op 0 returns b.
  - op 1 returns a.
  - op 5 returns a AND b.
  - op 6 returns a OR b.
  - op 7 returns a XOR b.
- R5: With `grp_sel`=1, `op_sel[1:0]` selects the function and `op_sel[2]` is ignored:
  - 0 gives a+1, with `carry`=1 when a is 0xFFFF.
  - 1 gives a-1, with `carry`=1 when a is non-zero.
  - 2 gives 0-a, with `carry`=1 when a is 0.
  - 3 gives NOT a, with `carry`=0.
- R6: With `grp_sel`=2, `imm[7:4]` selects the operation and `imm[3:0]` gives an amount n from 0 to 15:
  - 0 is a logical left shift of a by n.
  - 1 is a logical right shift by n.
  - 2 is an arithmetic right shift by n.
  - 3 is a left rotate by n.
  - `carry` is 0 for all four.
- R7: With `grp_sel`=2, `imm[7:4]` values 4 to 7 operate on bit `imm[3:0]` of a, with `carry`=0:
  - 4 clears that bit.
  - 5 sets it.
  - 6 inverts it.
  - 7 returns that bit in bit 0 of the result, with all other result bits 0.
- R8: With `grp_sel`=2 and `imm[7:4]` in the range 8 to 15, the result equals a and `carry` is 0.
- R9: With `grp_sel`=3, the result is a plus `imm` sign-extended to 16 bits, modulo 2^16. `carry` is the bit-16 carry-out of that sum. `op_sel` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| grp_sel | input | 2 | Operation group: 0 pair, 1 single, 2 shift/bit, 3 immediate add |
| op_sel | input | 3 | Function within groups 0 and 1 |
| src_a | input | 16 | Register a operand |
| src_b | input | 16 | Register b operand |
| pc_in | input | 16 | Current program counter value |
| imm | input | 8 | Immediate field |
| result | output | 16 | Registered result |
| carry | output | 1 | Registered carry / no-borrow bit |

## Verification
On every cycle the assertions check several properties against the inputs of the previous edge:

- the cleared state after reset;
- the no-borrow meaning of carry on subtract;
- that negation sums with the operand to zero;
- that bit extract leaves only bit 0 live;
- that toggle flips exactly one bit;
- that the unused immediate codes pass a through.

Full arithmetic correctness of every code depends on the bench's sweeps:

- each shift and bit code at all sixteen amounts;
- the wrap and carry edges around 0, 0x7FFF, 0x8000 and 0xFFFF;
- the sign extension of negative immediates.

// File: rtl/ccalu_pkg.sv
package ccalu_pkg;
  localparam logic [1:0] GRP_PAIR   = 2'd0;
  localparam logic [1:0] GRP_SINGLE = 2'd1;
  localparam logic [1:0] GRP_SHBIT  = 2'd2;
  localparam logic [1:0] GRP_ADDI   = 2'd3;

  localparam logic [2:0] P_COPYB = 3'd0;
  localparam logic [2:0] P_COPYA = 3'd1;
  localparam logic [2:0] P_ADD   = 3'd2;
  localparam logic [2:0] P_SUB   = 3'd3;
  localparam logic [2:0] P_ADDPC = 3'd4;
  localparam logic [2:0] P_AND   = 3'd5;
  localparam logic [2:0] P_OR    = 3'd6;
  localparam logic [2:0] P_XOR   = 3'd7;

  localparam logic [1:0] S_INC = 2'd0;
  localparam logic [1:0] S_DEC = 2'd1;
  localparam logic [1:0] S_NEG = 2'd2;
  localparam logic [1:0] S_NOT = 2'd3;

  localparam logic [3:0] I_LSL = 4'd0;
  localparam logic [3:0] I_LSR = 4'd1;
  localparam logic [3:0] I_ASR = 4'd2;
  localparam logic [3:0] I_ROL = 4'd3;
  localparam logic [3:0] I_CLR = 4'd4;
  localparam logic [3:0] I_SET = 4'd5;
  localparam logic [3:0] I_TOG = 4'd6;
  localparam logic [3:0] I_EXT = 4'd7;
endpackage

// File: rtl/ccalu_addsrc.sv
module ccalu_addsrc
  import ccalu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic [1:0]        grp,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] pc,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] x,
  output logic [DATA_W-1:0] y,
  output logic              cin
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sx;
  assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};

  // Operand steering for the single shared adder.
  always_comb begin
    x   = a;
    y   = b;
    cin = 1'b0;
    unique case (grp)
      GRP_PAIR: begin
        if (op == P_SUB) begin
          y   = ~b;
          cin = 1'b1;
        end else if (op == P_ADDPC) begin
          x = pc;
        end
      end
      GRP_SINGLE: begin
        unique case (op[1:0])
          S_INC: begin y = '0; cin = 1'b1; end
          S_DEC: begin y = '1; end
          S_NEG: begin x = '0; y = ~a; cin = 1'b1; end
          default: begin y = '0; end
        endcase
      end
      GRP_ADDI: y = imm_sx;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/ccalu_adder.sv
module ccalu_adder #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);
  logic [DATA_W:0] wide;
  assign wide = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
  assign sum  = wide[DATA_W-1:0];
  assign cout = wide[DATA_W];
endmodule

// File: rtl/ccalu_shbit.sv
module ccalu_shbit
  import ccalu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [3:0]        fn,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] st_l [0:AMT_W];
  logic [DATA_W-1:0] st_r [0:AMT_W];
  logic [DATA_W-1:0] st_s [0:AMT_W];
  logic [DATA_W-1:0] st_o [0:AMT_W];

  assign st_l[0] = a;
  assign st_r[0] = a;
  assign st_s[0] = a;
  assign st_o[0] = a;

  // Logarithmic barrel: stage s moves by 2^s when amt[s] is set.
  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign st_l[s+1] = amt[s] ? {st_l[s][DATA_W-1-SH:0], {SH{1'b0}}} : st_l[s];
    assign st_r[s+1] = amt[s] ? {{SH{1'b0}}, st_r[s][DATA_W-1:SH]} : st_r[s];
    assign st_s[s+1] = amt[s] ? {{SH{st_s[s][DATA_W-1]}}, st_s[s][DATA_W-1:SH]} : st_s[s];
    assign st_o[s+1] = amt[s] ? {st_o[s][DATA_W-1-SH:0], st_o[s][DATA_W-1 -: SH]} : st_o[s];
  end

  logic [DATA_W-1:0] onehot;
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign onehot[i] = (amt == AMT_W'(i));
  end

  always_comb begin
    unique case (fn)
      I_LSL:   y = st_l[AMT_W];
      I_LSR:   y = st_r[AMT_W];
      I_ASR:   y = st_s[AMT_W];
      I_ROL:   y = st_o[AMT_W];
      I_CLR:   y = a & ~onehot;
      I_SET:   y = a | onehot;
      I_TOG:   y = a ^ onehot;
      I_EXT:   y = {{(DATA_W-1){1'b0}}, |(a & onehot)};
      default: y = a;
    endcase
  end
endmodule

// File: rtl/ccalu_core.sv
module ccalu_core
  import ccalu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        grp_sel,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              carry
);
  localparam int AMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] add_x, add_y, add_sum, sh_y;
  logic              add_cin, add_cout;

  ccalu_addsrc #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_src (
    .grp(grp_sel), .op(op_sel), .a(src_a), .b(src_b), .pc(pc_in), .imm(imm),
    .x(add_x), .y(add_y), .cin(add_cin)
  );

  ccalu_adder #(.DATA_W(DATA_W)) u_add (
    .x(add_x), .y(add_y), .cin(add_cin), .sum(add_sum), .cout(add_cout)
  );

  ccalu_shbit #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shb (
    .a(src_a), .fn(imm[AMT_W +: 4]), .amt(imm[AMT_W-1:0]), .y(sh_y)
  );

  logic [DATA_W-1:0] res_d;
  logic              cy_d;

  always_comb begin
    res_d = add_sum;
    cy_d  = add_cout;
    unique case (grp_sel)
      GRP_PAIR: begin
        unique case (op_sel)
          P_COPYB: begin res_d = src_b;         cy_d = 1'b0; end
          P_COPYA: begin res_d = src_a;         cy_d = 1'b0; end
          P_AND:   begin res_d = src_a & src_b; cy_d = 1'b0; end
          P_OR:    begin res_d = src_a | src_b; cy_d = 1'b0; end
          P_XOR:   begin res_d = src_a ^ src_b; cy_d = 1'b0; end
          default: ;
        endcase
      end
      GRP_SINGLE: begin
        if (op_sel[1:0] == S_NOT) begin
          res_d = ~src_a;
          cy_d  = 1'b0;
        end
      end
      GRP_SHBIT: begin res_d = sh_y; cy_d = 1'b0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      carry  <= 1'b0;
    end else begin
      result <= res_d;
      carry  <= cy_d;
    end
  end

  // R1: cleared after a reset cycle
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && carry == 1'b0));

  // R3: carry means no borrow on subtract
  a_r3_sub_noborrow: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(grp_sel) == GRP_PAIR && $past(op_sel) == P_SUB)
      |-> (carry == ($past(src_a) >= $past(src_b))));

  // R5: negate sums with its operand to zero
  a_r5_neg_sums_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(grp_sel) == GRP_SINGLE && $past(op_sel[1:0]) == S_NEG)
      |-> (DATA_W'(result + $past(src_a)) == '0));

  // R7: extract leaves only bit 0 live
  a_r7_ext_narrow: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(grp_sel) == GRP_SHBIT && $past(imm[AMT_W +: 4]) == I_EXT)
      |-> (result[DATA_W-1:1] == '0 && carry == 1'b0));

  // R7: toggle flips exactly one bit
  a_r7_tog_one_bit: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(grp_sel) == GRP_SHBIT && $past(imm[AMT_W +: 4]) == I_TOG)
      |-> ($countones(result ^ $past(src_a)) == 1));

  // R8: spare immediate codes pass a through
  a_r8_spare_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(grp_sel) == GRP_SHBIT && $past(imm[AMT_W+3]))
      |-> (result == $past(src_a) && carry == 1'b0));
endmodule

// File: tb/tb_ccalu_core.sv
module tb_ccalu_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  grp_sel = '0;
  logic [2:0]  op_sel = '0;
  logic [15:0] src_a = '0, src_b = '0, pc_in = '0;
  logic [7:0]  imm = '0;
  logic [15:0] result;
  logic        carry;

  int checks = 0;
  int fails  = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccalu_core dut (
    .clk(clk), .rst(rst), .grp_sel(grp_sel), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .pc_in(pc_in), .imm(imm),
    .result(result), .carry(carry)
  );

  function automatic logic [31:0] nextrand(input logic [31:0] s);
    logic [31:0] v = s;
    v ^= v << 13;
    v ^= v >> 17;
    v ^= v << 5;
    return v;
  endfunction

  // Independent reference: returns {carry, result}
  function automatic logic [16:0] model(input logic [1:0] g, input logic [2:0] o,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] p,
      input logic [7:0] i);
    int n = int'(i[3:0]);
    int ua = int'(a);
    int ub = int'(b);
    logic [31:0] w;
    case (g)
      2'd0: case (o)
        3'd0: return {1'b0, b};
        3'd1: return {1'b0, a};
        3'd2: return 17'(ua + ub);
        3'd3: return {(ua >= ub), 16'(ua - ub)};
        3'd4: return 17'(int'(p) + ub);
        3'd5: return {1'b0, a & b};
        3'd6: return {1'b0, a | b};
        default: return {1'b0, a ^ b};
      endcase
      2'd1: case (o[1:0])
        2'd0: return {(ua == 65535), 16'(ua + 1)};
        2'd1: return {(ua != 0), 16'(ua - 1)};
        2'd2: return {(ua == 0), 16'(0 - ua)};
        default: return {1'b0, ~a};
      endcase
      2'd2: begin
        case (i[7:4])
          4'd0: w = 32'(ua) << n;
          4'd1: w = 32'(ua) >> n;
          4'd2: w = 32'(($signed({{16{a[15]}}, a})) >>> n);
          4'd3: w = (32'(ua) << n) | (32'(ua) >> (16 - n));
          4'd4: w = 32'(ua) & ~(32'd1 << n);
          4'd5: w = 32'(ua) | (32'd1 << n);
          4'd6: w = 32'(ua) ^ (32'd1 << n);
          4'd7: w = (32'(ua) >> n) & 32'd1;
          default: w = 32'(ua);
        endcase
        return {1'b0, w[15:0]};
      end
      default: return 17'(ua + int'({{8{i[7]}}, i}));
    endcase
  endfunction

  function automatic string tag(input logic [1:0] g, input logic [2:0] o, input logic [7:0] i);
    if (g == 2'd0) return (o == 3'd3) ? "R3" : ((o == 3'd2 || o == 3'd4) ? "R2" : "R4");
    if (g == 2'd1) return "R5";
    if (g == 2'd2) return (i[7:4] < 4) ? "R6" : ((i[7:4] < 8) ? "R7" : "R8");
    return "R9";
  endfunction

  task automatic run(input logic [1:0] g, input logic [2:0] o, input logic [15:0] a,
      input logic [15:0] b, input logic [15:0] p, input logic [7:0] i);
    logic [16:0] exp;
    @(negedge clk);
    grp_sel = g; op_sel = o; src_a = a; src_b = b; pc_in = p; imm = i;
    exp = model(g, o, a, b, p, i);
    @(negedge clk);
    checks++;
    if ({carry, result} !== exp) begin
      fails++;
      $display("FAIL %s grp=%0d op=%0d a=%h b=%h pc=%h imm=%h actual c=%b r=%h expected c=%b r=%h",
        tag(g, o, i), g, o, a, b, p, i, carry, result, exp[16], exp[15:0]);
    end
  endtask

  task automatic check_reset();
    checks++;
    if (result !== 16'h0 || carry !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset actual c=%b r=%h expected c=0 r=0000", carry, result);
    end
  endtask

  logic [15:0] edges [0:5] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001, 16'hA5C3};

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: held reset with live inputs keeps outputs cleared
    grp_sel = 2'd3; src_a = 16'hFFFF; imm = 8'h7F;
    repeat (3) @(negedge clk);
    check_reset();
    rst = 1'b0;

    // R2 R3 R4: pair group, edge grid and random
    for (int o = 0; o < 8; o++) begin
      for (int x = 0; x < 6; x++)
        for (int y = 0; y < 6; y++)
          run(2'd0, 3'(o), edges[x], edges[y], edges[(x+y)%6], 8'h00);
      for (int k = 0; k < 60; k++) begin
        seed = nextrand(seed);
        run(2'd0, 3'(o), seed[15:0], seed[31:16], seed[23:8], 8'h00);
      end
    end

    // R5: single group, op_sel[2] ignored
    for (int o = 0; o < 8; o++) begin
      for (int x = 0; x < 6; x++) run(2'd1, 3'(o), edges[x], 16'h1357, 16'h0, 8'hFF);
      for (int k = 0; k < 30; k++) begin
        seed = nextrand(seed);
        run(2'd1, 3'(o), seed[15:0], seed[31:16], 16'h0, seed[7:0]);
      end
    end

    // R6 R7 R8: every immediate code and amount
    for (int i = 0; i < 256; i++) begin
      for (int x = 0; x < 6; x++) run(2'd2, 3'd5, edges[x], 16'hFFFF, 16'h0, 8'(i));
      for (int k = 0; k < 6; k++) begin
        seed = nextrand(seed);
        run(2'd2, seed[2:0], seed[15:0], seed[31:16], 16'h0, 8'(i));
      end
    end

    // R9: signed immediate add over every immediate
    for (int i = 0; i < 256; i++) begin
      for (int x = 0; x < 6; x++) run(2'd3, 3'(i), edges[x], 16'h0, 16'h0, 8'(i));
      seed = nextrand(seed);
      run(2'd3, 3'd0, seed[15:0], 16'h0, 16'h0, 8'(i));
    end

    // R1: mid-run synchronous reset
    @(negedge clk);
    grp_sel = 2'd0; op_sel = 3'd1; src_a = 16'hBEEF; rst = 1'b1;
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    run(2'd0, 3'd1, 16'hBEEF, 16'h0, 16'h0, 8'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule